// File: doc/BRIEF.md
# Flash Write-Control Register and Pulse Sequencer

This block holds the 16-bit control and status word that governs program and erase work on an on-chip flash array. It sits on a word-wide CPU bus. Every even word address inside the flash address window reaches the same register. In standard mode the register is hidden: reads return zero and writes are ignored, with one exception for the protect bit. A two-word unlock sequence switches the block into writing mode, and only then can software select an operation and read status.

When software asserts a separate launch strobe, a pulse sequencer starts a timed operation on a small behavioural flash-cell model. The pulse width comes from the clock-control field. The operation ends when the cell model reports completion or when a pulse ceiling is reached. The block also tracks a live supply-OK input and a sticky supply-dropout flag, drives a verify indication for reads made while writing is enabled, decodes the bank of the accessed address, and raises a trap for word accesses at odd addresses in the window.

Top module: `flash_wctl`

## Requirements
- R1: After reset, writing mode is off, `busy` is 0, `protect` is 1, `acc_trap` is 0, and `bus_rdata` reads 0000h.
- R2: A word write of A5A5h to an even window address, followed by a word write of 5A5Ah to an even window address as the very next bus access, enters writing mode. After that, reads return bit 15 = 1. Any other access between the two words, inside or outside the window, cancels the sequence. Only the bus accesses themselves count toward "next"; idle cycles between them do not.
- R3: In standard mode, reads in the window return 0000h. Writes in the window other than the protect case of R10 leave all fields unchanged.
- R4: In writing mode, a write whose bit 15 is 0 leaves writing mode and changes no other field. Those fields read back unchanged after re-entry.
- R5: One cycle after any access to an odd address inside the window, `acc_trap` is 1 for one cycle. Even addresses, and odd addresses outside the window, give no trap. The window is 000000h–007FFFh plus 018000h–02FFFFh.
- R6: A read in writing mode returns the following fields:
  - bit 15 = 1
  - bits 14..10 = 0
  - bits 9..8 = erase bank
  - bit 7 = 32-bit width
  - bits 6..5 = clock control
  - bit 4 = live `supply_ok`
  - bit 3 = sticky supply fault
  - bit 2 = busy
  - bit 1 = erase select
  - bit 0 = write enable
- R7: `launch` starts an operation only when writing mode is on, write enable is 1, and the block is not busy. In that case `busy` and read bit 2 are 1 from the cycle after the launch edge. Choosing a mode with a write does not start anything.
- R8: An operation stays busy for exactly min(need, 8) × 2^(4+clock control) cycles. For a program, need is 1 at 16-bit width and 2 at 32-bit width. For an erase, need is 2 + 3 × bank.
- R9: The fault flag (read bit 3) sets when `supply_ok` is low during any busy cycle. It holds until the next accepted launch or a reset.
- R10: `protect` resets to 1 and takes write-data bit 2 only from writes fetched from flash (`bus_from_flash` = 1). This applies to non-key writes in standard mode and to writes with bit 15 = 1 in writing mode. The key words never change it.
- R11: In writing mode with write enable set, a window read drives `verify_rd` high. `verify_bank` gives the bank of the address:
  - bank 0: 000000h–007FFFh and 018000h–01BFFFh
  - bank 1: 01C000h–027FFFh
  - bank 2: 028000h–02DFFFh
  - bank 3: 02E000h–02FFFFh
- R12: While busy, all register writes are ignored, including exit writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 24 | Byte address of the word access |
| bus_wdata | input | 16 | Write data |
| bus_from_flash | input | 1 | The accessing instruction was fetched from flash |
| bus_rdata | output | 16 | Register read data (0 when hidden) |
| acc_trap | output | 1 | Illegal odd-address access trap pulse |
| launch | input | 1 | Start command for the selected operation |
| supply_ok | input | 1 | Programming supply above threshold |
| busy | output | 1 | Operation in progress |
| protect | output | 1 | Protect bit state |
| verify_rd | output | 1 | Current read is a verify read |
| verify_bank | output | 2 | Bank decoded from bus_addr |

## Verification
A configuration write and a launch strobe can land on the same clock edge. The bench drives both together, with a write that raises the clock-control field. It judges the outcome in two ways: the measured busy length must match the old pulse width, and a later read must show the new field value. A supply dropout that coincides with busy pulses is also provoked, then judged by the sticky flag after completion and by its clearing on the next launch.

// File: rtl/fcr_pkg.sv
package fcr_pkg;
    localparam int unsigned ADDR_W = 24;
    localparam int unsigned WORD_W = 16;
    localparam logic [WORD_W-1:0] KEY_FIRST  = 16'hA5A5;
    localparam logic [WORD_W-1:0] KEY_SECOND = 16'h5A5A;

    typedef struct packed {
        logic [1:0] bank;
        logic       wide;
        logic [1:0] ck;
        logic       erase;
        logic       wen;
    } fcr_cfg_t;

    typedef struct packed {
        logic       erase;
        logic [1:0] bank;
        logic       wide;
    } fcr_op_t;

    function automatic logic in_window(input logic [ADDR_W-1:0] a);
        return (a < 24'h008000) || ((a >= 24'h018000) && (a < 24'h030000));
    endfunction

    function automatic logic [1:0] bank_of(input logic [ADDR_W-1:0] a);
        if (a < 24'h01C000)      return 2'd0;
        else if (a < 24'h028000) return 2'd1;
        else if (a < 24'h02E000) return 2'd2;
        else                     return 2'd3;
    endfunction

    function automatic logic [WORD_W-1:0] pack_status(input fcr_cfg_t c, input logic sup,
                                                      input logic flt, input logic bsy);
        return {1'b1, 5'b0, c.bank, c.wide, c.ck, sup, flt, bsy, c.erase, c.wen};
    endfunction
endpackage

// File: rtl/fcr_keydet.sv
module fcr_keydet (
    input  logic clk,
    input  logic rst,
    input  logic acc_req,
    input  logic first_hit,
    input  logic second_hit,
    output logic enter
);
    logic armed;

    always_ff @(posedge clk) begin
        if (rst)          armed <= 1'b0;
        else if (acc_req) armed <= first_hit;
    end

    assign enter = armed & second_hit;
endmodule

// File: rtl/fcr_pulse_seq.sv
module fcr_pulse_seq #(
    parameter int unsigned CK_BASE    = 4,
    parameter int unsigned MAX_PULSES = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [1:0] ck,
    input  logic       cell_done,
    output logic       busy,
    output logic       pulse_end
);
    localparam int unsigned CNT_W = CK_BASE + 3;
    localparam int unsigned PN_W  = $clog2(MAX_PULSES + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;
    logic [PN_W-1:0]  pn;
    logic [1:0]       ck_q;
    logic             last;

    always_comb lim = CNT_W'((32'd1 << (CK_BASE + 32'(ck_q))) - 32'd1);
    assign last      = (cnt == lim);
    assign pulse_end = busy & last;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
            pn   <= '0;
            ck_q <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= '0;
            pn   <= '0;
            ck_q <= ck;
        end else if (busy) begin
            if (last) begin
                cnt <= '0;
                pn  <= pn + 1'b1;
                if (cell_done || (pn == PN_W'(MAX_PULSES - 1))) busy <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/fcr_cell_model.sv
module fcr_cell_model
    import fcr_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  logic    pulse_end,
    input  fcr_op_t op,
    output logic    done
);
    logic [4:0] pcnt;
    logic [4:0] need;

    always_comb begin
        if (op.erase) need = 5'd2 + 5'd3 * {3'b0, op.bank};
        else          need = op.wide ? 5'd2 : 5'd1;
    end

    assign done = pulse_end && ((pcnt + 5'd1) == need);

    always_ff @(posedge clk) begin
        if (rst || start)   pcnt <= '0;
        else if (pulse_end) pcnt <= pcnt + 5'd1;
    end
endmodule

// File: rtl/flash_wctl.sv
module flash_wctl
    import fcr_pkg::*;
#(
    parameter int unsigned CK_BASE    = 4,
    parameter int unsigned MAX_PULSES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    input  logic              bus_from_flash,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              acc_trap,
    input  logic              launch,
    input  logic              supply_ok,
    output logic              busy,
    output logic              protect,
    output logic              verify_rd,
    output logic [1:0]        verify_bank
);
    logic     wmode;
    logic     fault;
    fcr_cfg_t cfg_q;
    fcr_op_t  op_q;
    logic     win, hit, wr_hit;
    logic     key_a, key_b, enter;
    logic     cfg_wr, exit_wr, std_prot, go;
    logic     pulse_end, cell_done;

    assign win     = in_window(bus_addr);
    assign hit     = bus_req & win & ~bus_addr[0];
    assign wr_hit  = hit & bus_we;
    assign key_a   = wr_hit & ~wmode & (bus_wdata == KEY_FIRST);
    assign key_b   = wr_hit & ~wmode & (bus_wdata == KEY_SECOND);
    assign cfg_wr  = wr_hit & wmode & ~busy & bus_wdata[15];
    assign exit_wr = wr_hit & wmode & ~busy & ~bus_wdata[15];
    assign std_prot = wr_hit & ~wmode & bus_from_flash &
                      (bus_wdata != KEY_FIRST) & (bus_wdata != KEY_SECOND);
    assign go      = launch & wmode & cfg_q.wen & ~busy;

    fcr_keydet u_key (
        .clk       (clk),
        .rst       (rst),
        .acc_req   (bus_req),
        .first_hit (key_a),
        .second_hit(key_b),
        .enter     (enter)
    );

    fcr_pulse_seq #(.CK_BASE(CK_BASE), .MAX_PULSES(MAX_PULSES)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (go),
        .ck       (cfg_q.ck),
        .cell_done(cell_done),
        .busy     (busy),
        .pulse_end(pulse_end)
    );

    fcr_cell_model u_cell (
        .clk      (clk),
        .rst      (rst),
        .start    (go),
        .pulse_end(pulse_end),
        .op       (op_q),
        .done     (cell_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wmode    <= 1'b0;
            cfg_q    <= '0;
            op_q     <= '0;
            protect  <= 1'b1;
            fault    <= 1'b0;
            acc_trap <= 1'b0;
        end else begin
            acc_trap <= bus_req & win & bus_addr[0];
            if (enter)        wmode <= 1'b1;
            else if (exit_wr) wmode <= 1'b0;
            if (cfg_wr) begin
                cfg_q.bank  <= bus_wdata[9:8];
                cfg_q.wide  <= bus_wdata[7];
                cfg_q.ck    <= bus_wdata[6:5];
                cfg_q.erase <= bus_wdata[1];
                cfg_q.wen   <= bus_wdata[0];
                if (bus_from_flash) protect <= bus_wdata[2];
            end
            if (std_prot) protect <= bus_wdata[2];
            if (go) begin
                op_q  <= '{erase: cfg_q.erase, bank: cfg_q.bank, wide: cfg_q.wide};
                fault <= 1'b0;
            end else if (busy && !supply_ok) begin
                fault <= 1'b1;
            end
        end
    end

    assign bus_rdata   = (hit & ~bus_we & wmode) ? pack_status(cfg_q, supply_ok, fault, busy) : '0;
    assign verify_rd   = bus_req & ~bus_we & win & wmode & cfg_q.wen;
    assign verify_bank = bank_of(bus_addr);
endmodule

// File: rtl/flash_wctl_chk.sv
module flash_wctl_chk
    import fcr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [WORD_W-1:0] bus_wdata,
    input logic              bus_from_flash,
    input logic              launch,
    input logic              supply_ok,
    input logic              busy,
    input logic              protect,
    input logic              acc_trap,
    input logic              wmode,
    input logic              fault
);
    // R2
    enter_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(wmode) |-> $past(bus_req && bus_we && bus_wdata == KEY_SECOND));

    // R4
    exit_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_we && !bus_addr[0] && in_window(bus_addr) && wmode && !busy && !bus_wdata[15])
        |=> !wmode);

    // R5
    trap_src_chk: assert property (@(posedge clk) disable iff (rst)
        acc_trap |-> $past(bus_req && bus_addr[0] && in_window(bus_addr)));

    // R7
    busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(launch && wmode));

    // R9
    fault_set_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !supply_ok) |=> fault);

    // R10
    prot_src_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(protect) |-> $past(bus_req && bus_we && bus_from_flash));

    // R12
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(wmode));
endmodule

bind flash_wctl flash_wctl_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .bus_req       (bus_req),
    .bus_we        (bus_we),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .bus_from_flash(bus_from_flash),
    .launch        (launch),
    .supply_ok     (supply_ok),
    .busy          (busy),
    .protect       (protect),
    .acc_trap      (acc_trap),
    .wmode         (wmode),
    .fault         (fault)
);

// File: tb/flash_wctl_tb.sv
module flash_wctl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [23:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        bus_from_flash = 1'b0;
    logic [15:0] bus_rdata;
    logic        acc_trap;
    logic        launch = 1'b0;
    logic        supply_ok = 1'b1;
    logic        busy;
    logic        protect;
    logic        verify_rd;
    logic [1:0]  verify_bank;

    int n_chk = 0;
    int n_fail = 0;
    bit done_flag = 0;

    always #2 clk = ~clk;

    flash_wctl u_dut (
        .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_from_flash(bus_from_flash), .bus_rdata(bus_rdata),
        .acc_trap(acc_trap), .launch(launch), .supply_ok(supply_ok), .busy(busy),
        .protect(protect), .verify_rd(verify_rd), .verify_bank(verify_bank)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] sv(input int bank, input bit wide, input int ck, input bit sup,
                                       input bit flt, input bit bsy, input bit ers, input bit wen);
        return 16'h8000 | 16'(bank << 8) | 16'(wide << 7) | 16'(ck << 5) | 16'(sup << 4)
             | 16'(flt << 3) | 16'(bsy << 2) | 16'(ers << 1) | 16'(wen);
    endfunction

    task automatic wr(input logic [23:0] a, input logic [15:0] d, input bit ff);
        @(negedge clk);
        bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d; bus_from_flash = ff;
        @(posedge clk); #1;
        bus_req = 0; bus_we = 0; bus_from_flash = 0;
    endtask

    task automatic rd(input logic [23:0] a, output logic [15:0] v);
        @(negedge clk);
        bus_req = 1; bus_we = 0; bus_addr = a;
        #1 v = bus_rdata;
        @(posedge clk); #1;
        bus_req = 0;
    endtask

    task automatic unlock();
        wr(24'h000010, 16'hA5A5, 0);
        wr(24'h020000, 16'h5A5A, 0);
    endtask

    task automatic fire();
        @(negedge clk); launch = 1;
        @(posedge clk); #1 launch = 0;
    endtask

    task automatic measure(output int n);
        n = 0;
        while (busy && n < 5000) begin
            n++;
            @(posedge clk); #1;
        end
    endtask

    function automatic int min_pulses(input bit ers, input int bank, input bit wide);
        int need;
        need = ers ? (2 + 3 * bank) : (wide ? 2 : 1);
        return (need < 8) ? need : 8;
    endfunction

    initial begin
        #(4 * 150000);
        if (!done_flag) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        int n;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;
        @(posedge clk); #1;

        // R1 reset state
        check("R1 busy", busy, 0);
        check("R1 protect", protect, 1);
        check("R1 trap", acc_trap, 0);
        rd(24'h000100, v); check("R1 rdata", v, 0);

        // R10 protect in standard mode
        wr(24'h000200, 16'h0000, 1); check("R10 flash write clears", protect, 0);
        wr(24'h000200, 16'h0004, 0); check("R10 non-flash ignored", protect, 0);
        wr(24'h000200, 16'h0004, 1); check("R10 flash write sets", protect, 1);
        wr(24'h000200, 16'h0000, 1);
        wr(24'h000200, 16'hA5A5, 1); check("R10 key word ignored", protect, 0);
        wr(24'h000200, 16'h5A5A, 1); check("R10 key word ignored 2", protect, 0);
        // R2 mode entered
        rd(24'h000300, v); check("R2 entered", v, 16'h8010);
        wr(24'h000200, 16'h8004, 1); check("R10 mode write from flash", protect, 1);

        // R4 / R3 exit and hidden
        wr(24'h000200, 16'h0000, 0);
        rd(24'h000200, v); check("R3 hidden after exit", v, 0);

        // R2 interrupted sequences
        wr(24'h000400, 16'hA5A5, 0); rd(24'h000400, v); wr(24'h000400, 16'h5A5A, 0);
        rd(24'h000400, v); check("R2 read breaks key", v, 0);
        wr(24'h000400, 16'hA5A5, 0); wr(24'h050000, 16'h1234, 0); wr(24'h000400, 16'h5A5A, 0);
        rd(24'h000400, v); check("R2 outside access breaks key", v, 0);

        // R3 standard write ignored
        wr(24'h000400, 16'h83F3, 0);
        unlock(); rd(24'h000400, v); check("R3 std write no effect", v, 16'h8010);

        // R6 field layout
        wr(24'h000400, 16'hFFFF, 0);
        rd(24'h000400, v); check("R6 layout", v, sv(3, 1, 3, 1, 0, 0, 1, 1));
        supply_ok = 0;
        rd(24'h000400, v); check("R6 live supply", v, sv(3, 1, 3, 0, 0, 0, 1, 1));
        supply_ok = 1;

        // R4 exit keeps fields
        wr(24'h000400, 16'h7FFF, 0);
        rd(24'h000400, v); check("R4 exited", v, 0);
        unlock(); rd(24'h000400, v); check("R4 fields kept", v, sv(3, 1, 3, 1, 0, 0, 1, 1));

        // R5 traps
        rd(24'h000401, v); check("R5 odd in window", acc_trap, 1);
        @(posedge clk); #1 check("R5 trap one cycle", acc_trap, 0);
        wr(24'h028001, 16'h0000, 0); check("R5 odd write in window", acc_trap, 1);
        rd(24'h040001, v); check("R5 odd outside window", acc_trap, 0);
        rd(24'h010001, v); check("R5 odd in gap", acc_trap, 0);
        rd(24'h000402, v); check("R5 even no trap", acc_trap, 0);

        // R7 launch gating
        wr(24'h000400, 16'h8000, 0); fire(); check("R7 wen=0 no start", busy, 0);
        wr(24'h000400, 16'h8001, 0); wr(24'h000400, 16'h0000, 0);
        fire(); check("R7 std mode no start", busy, 0);
        unlock();
        rd(24'h000400, v); check("R7 select does not start", v, sv(0, 0, 0, 1, 0, 0, 0, 1));

        // R8 duration sweep
        for (int kind = 0; kind < 6; kind++) begin
            for (int ck = 0; ck < 4; ck++) begin
                bit ers; bit wide; int bank;
                ers  = (kind >= 2);
                wide = (kind == 1);
                bank = ers ? kind - 2 : 0;
                wr(24'h000400, sv(bank, wide, ck, 0, 0, 0, ers, 1), 0);
                fire();
                check("R7 busy after launch", busy, 1);
                measure(n);
                check($sformatf("R8 kind%0d ck%0d", kind, ck), n, min_pulses(ers, bank, wide) * (1 << (4 + ck)));
            end
        end

        // same-cycle config write and launch
        wr(24'h000400, 16'h8001, 0);
        @(negedge clk);
        bus_req = 1; bus_we = 1; bus_addr = 24'h000400; bus_wdata = 16'h8061; launch = 1;
        @(posedge clk); #1 bus_req = 0; bus_we = 0; launch = 0;
        measure(n); check("R8 launch uses old ck", n, 16);
        rd(24'h000400, v); check("R6 new ck stored", v, sv(0, 0, 3, 1, 0, 0, 0, 1));

        // R12 writes ignored while busy
        wr(24'h000400, 16'h8103, 0);
        fire();
        wr(24'h000400, 16'h8001, 0);
        wr(24'h000400, 16'h0000, 0);
        check("R12 still busy", busy, 1);
        measure(n); check("R12 duration unchanged", n + 2, 80);
        rd(24'h000400, v); check("R12 cfg and mode kept", v, sv(1, 0, 0, 1, 0, 0, 1, 1));

        // R9 sticky fault
        wr(24'h000400, 16'h8003, 0);
        fire();
        @(negedge clk) supply_ok = 0;
        @(negedge clk) supply_ok = 1;
        measure(n);
        rd(24'h000400, v); check("R9 fault latched", v, sv(0, 0, 0, 1, 1, 0, 1, 1));
        fire();
        rd(24'h000400, v); check("R9 fault cleared on launch", v, sv(0, 0, 0, 1, 0, 1, 1, 1));
        measure(n);

        // R11 verify reads and bank map
        wr(24'h000400, 16'h8001, 0);
        for (int a = 0; a < 'h30000; a += 'h1000) begin
            int eb; bit inw;
            inw = (a < 'h8000) || (a >= 'h18000);
            eb = (a < 'h1C000) ? 0 : (a < 'h28000) ? 1 : (a < 'h2E000) ? 2 : 3;
            @(negedge clk);
            bus_req = 1; bus_we = 0; bus_addr = 24'(a);
            #1;
            check($sformatf("R11 verify %0h", a), verify_rd, inw);
            if (inw) check($sformatf("R11 bank %0h", a), verify_bank, eb);
            @(posedge clk); #1 bus_req = 0;
        end
        wr(24'h000400, 16'h8000, 0);
        @(negedge clk); bus_req = 1; bus_we = 0; bus_addr = 24'h020000;
        #1 check("R11 no verify when wen=0", verify_rd, 0);
        @(posedge clk); #1 bus_req = 0;

        done_flag = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule